// File: doc/BRIEF.md
# Polarity-Selectable Channel Input Combiner

This block forms the gate-on request for each channel of a four-channel low-side switch controller. Every channel has a parallel control pin. A single polarity strap sets whether a pin counts as asserted when it is high or when it is low. Both the pins and the strap are brought into the clock domain through a chain of flip-flops. The block then merges each normalised pin level with that channel's data bit from the serial register. A stored merge mode selects the operator, either OR or AND.

The command decoder sets the merge mode with two one-cycle strobes, one that selects OR and one that selects AND. Reset always returns the mode to OR. Each channel also has a protection input that forces its request off for as long as it is active. The normalised pin levels are exported for read-back. They are driven straight from the synchroniser, with no extra register stage. Holding the active-low reset low is the sleep state: both the requests and the read-back are all zero.

Top module: `gate_req_merge`

## Requirements
- R1: Pin n, data bit n and protection input n affect only request bit n and read-back bit n. No other channel changes.
- R2: With the strap at 1, a high pin reads back as 1 on `pin_norm`. With the strap at 0, a low pin reads back as 1.
- R3: A change on a pin or on the strap appears on `pin_norm` and on `gate_req` after exactly SYNC_STAGES rising clock edges (2 by default), and not earlier.
- R4: In OR mode, `gate_req[n]` = `pin_norm[n]` OR `data_bits[n]` for every unprotected channel.
- R5: In AND mode, `gate_req[n]` = `pin_norm[n]` AND `data_bits[n]` for every unprotected channel.
- R6: The first cycle after reset is released runs in OR mode. With all data bits at 0, the requests follow the normalised pins.
- R7: A cycle with only `set_and` high selects AND mode from the next cycle on. A cycle with only `set_or` high selects OR mode. A cycle with both strobes high, or with neither, leaves the mode unchanged.
- R8: While `rst_n` is low, `gate_req` and `pin_norm` are all 0, whatever the pins, the strap and the data bits are.
- R9: While `prot_off[n]` is 1, `gate_req[n]` is 0 in the same cycle. When the input is released, the merged value returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset and sleep |
| pin_raw | input | NCH | Raw parallel control pins, one per channel |
| pol_strap | input | 1 | Polarity strap: 1 = pins asserted high, 0 = pins asserted low |
| data_bits | input | NCH | Per-channel data bits from the serial register |
| set_or | input | 1 | One-cycle strobe that selects OR merging |
| set_and | input | 1 | One-cycle strobe that selects AND merging |
| prot_off | input | NCH | Per-channel force-off from the protection logic |
| gate_req | output | NCH | Per-channel gate-on request |
| pin_norm | output | NCH | Synchronised, polarity-normalised pin levels for read-back |

## Verification
The bench builds the block with its defaults: four channels and a two-stage synchroniser. With four channels, every pin/data combination of a channel is reached within a few hundred random cycles. Two stages make the edge-exact latency check of R3 meaningful, because the first edge after a change must still show the old level. The behavioural model delays the pins and the strap with a queue as deep as the synchroniser. Against that model, random strap flips, conflicting strobes, protection pulses and mid-run resets can be compared on every cycle.

// File: rtl/gate_req_merge_pkg.sv
package gate_req_merge_pkg;

    typedef enum logic {
        MERGE_OR  = 1'b0,
        MERGE_AND = 1'b1
    } merge_mode_e;

    typedef struct packed {
        logic norm;
        logic data;
        logic blocked;
    } lane_in_t;

    function automatic logic normalize(input logic raw, input logic active_high);
        return active_high ? raw : ~raw;
    endfunction

    function automatic logic merge(input lane_in_t li, input merge_mode_e mode);
        logic m;
        m = (mode == MERGE_AND) ? (li.norm & li.data) : (li.norm | li.data);
        return m & ~li.blocked;
    endfunction

endpackage

// File: rtl/gate_req_sync.sv
module gate_req_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gate_req_mode.sv
module gate_req_mode
    import gate_req_merge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_or,
    input  logic        set_and,
    output merge_mode_e mode
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MERGE_OR;
        else if (set_and && !set_or)
            mode <= MERGE_AND;
        else if (set_or && !set_and)
            mode <= MERGE_OR;
    end
endmodule

// File: rtl/gate_req_lane.sv
module gate_req_lane
    import gate_req_merge_pkg::*;
(
    input  logic        awake,
    input  logic        raw_s,
    input  logic        active_high,
    input  logic        data,
    input  logic        blocked,
    input  merge_mode_e mode,
    output logic        norm,
    output logic        req
);
    lane_in_t li;

    always_comb begin
        li.norm    = awake & normalize(raw_s, active_high);
        li.data    = data;
        li.blocked = blocked | ~awake;
        norm       = li.norm;
        req        = merge(li, mode);
    end
endmodule

// File: rtl/gate_req_merge.sv
module gate_req_merge
    import gate_req_merge_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_raw,
    input  logic           pol_strap,
    input  logic [NCH-1:0] data_bits,
    input  logic           set_or,
    input  logic           set_and,
    input  logic [NCH-1:0] prot_off,
    output logic [NCH-1:0] gate_req,
    output logic [NCH-1:0] pin_norm
);
    localparam int SW = NCH + 1;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {NCH{1'b0}}};

    logic [SW-1:0] synced;
    merge_mode_e   mode_q;

    gate_req_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({pol_strap, pin_raw}),
        .q    (synced)
    );

    gate_req_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_or (set_or),
        .set_and(set_and),
        .mode   (mode_q)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_lane
        gate_req_lane u_lane (
            .awake      (rst_n),
            .raw_s      (synced[n]),
            .active_high(synced[NCH]),
            .data       (data_bits[n]),
            .blocked    (prot_off[n]),
            .mode       (mode_q),
            .norm       (pin_norm[n]),
            .req        (gate_req[n])
        );
    end
endmodule

// File: rtl/gate_req_merge_chk.sv
module gate_req_merge_chk
    import gate_req_merge_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           set_or,
    input logic           set_and,
    input logic [NCH-1:0] prot_off,
    input logic [NCH-1:0] gate_req,
    input logic [NCH-1:0] pin_norm,
    input merge_mode_e    mode_q
);
    // R8
    sleep_off_chk: assert property (@(posedge clk)
        !rst_n |-> (gate_req == '0 && pin_norm == '0));

    // R6
    reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mode_q == MERGE_OR);

    // R7
    and_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_and && !set_or) |=> mode_q == MERGE_AND);

    // R7
    or_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_or && !set_and) |=> mode_q == MERGE_OR);

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_or == set_and) |=> $stable(mode_q));

    // R9
    prot_force_chk: assert property (@(posedge clk)
        (prot_off & gate_req) == '0);

    // R4
    or_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MERGE_OR) |-> ((pin_norm & ~prot_off & ~gate_req) == '0));

    // R5
    and_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MERGE_AND) |-> ((gate_req & ~pin_norm) == '0));
endmodule

bind gate_req_merge gate_req_merge_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_or  (set_or),
    .set_and (set_and),
    .prot_off(prot_off),
    .gate_req(gate_req),
    .pin_norm(pin_norm),
    .mode_q  (mode_q)
);

// File: tb/sim_gate_req_merge.sv
module sim_gate_req_merge;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int SYNC       = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin_raw = '0;
    logic           pol_strap = 1'b1;
    logic [NCH-1:0] data_bits = '0;
    logic           set_or = 1'b0;
    logic           set_and = 1'b0;
    logic [NCH-1:0] prot_off = '0;
    logic [NCH-1:0] gate_req;
    logic [NCH-1:0] pin_norm;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit cmp_en = 0;

    gate_req_merge #(.NCH(NCH), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pol_strap(pol_strap),
        .data_bits(data_bits), .set_or(set_or), .set_and(set_and),
        .prot_off(prot_off), .gate_req(gate_req), .pin_norm(pin_norm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: a delay queue for {strap, pins} and a mode flag
    logic [NCH:0] hist[$];
    bit model_and = 0;

    always @(posedge clk) begin
        logic [NCH-1:0] en, eg;
        logic [NCH:0]   h;
        string          tg;
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < SYNC; i++) hist.push_back({1'b1, {NCH{1'b0}}});
            model_and = 0;
        end else begin
            void'(hist.pop_front());
            hist.push_back({pol_strap, pin_raw});
            if (set_and && !set_or) model_and = 1;
            else if (set_or && !set_and) model_and = 0;
        end
        #(CLK_PERIOD/4);
        if (cmp_en) begin
            h = hist[0];
            for (int i = 0; i < NCH; i++) begin
                if (!rst_n) en[i] = 1'b0;
                else if (h[NCH]) en[i] = h[i];
                else en[i] = !h[i];
                if (!rst_n || prot_off[i]) eg[i] = 1'b0;
                else if (model_and) eg[i] = en[i] && data_bits[i];
                else eg[i] = en[i] || data_bits[i];
            end
            if (!rst_n) tg = "R8";
            else if (prot_off != '0) tg = "R9";
            else if (model_and) tg = "R5";
            else tg = "R4";
            chk({tg, " gate_req"}, gate_req, eg);
            chk(rst_n ? "R2 R3 pin_norm" : "R8 pin_norm", pin_norm, en);
        end
    end

    task automatic at_check();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic pulse(input bit o, input bit a);
        @(negedge clk); set_or = o; set_and = a;
        @(negedge clk); set_or = 0; set_and = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pin_raw = '1;
        data_bits = 4'b1010;
        cmp_en = 1;
        at_check();
        chk("R8 sleep gate_req", gate_req, '0);
        chk("R8 sleep pin_norm", pin_norm, '0);
        @(negedge clk); @(negedge clk);
        data_bits = '0; rst_n = 1;
        at_check(); at_check();
        chk("R6 default OR follows pins", gate_req, 4'b1111);
        @(negedge clk); pin_raw = 4'b0100;
        at_check(); at_check();
        chk("R1 single channel", gate_req, 4'b0100);
        @(negedge clk); pin_raw = 4'b0101;
        at_check();
        chk("R3 not yet after one edge", pin_norm, 4'b0100);
        at_check();
        chk("R3 visible after two edges", pin_norm, 4'b0101);
        @(negedge clk); pol_strap = 0; pin_raw = 4'b0000;
        at_check(); at_check();
        chk("R2 active-low strap", pin_norm, 4'b1111);
        pulse(0, 1);
        @(negedge clk); pin_raw = 4'b1010; data_bits = 4'b0011;
        at_check(); at_check();
        chk("R5 AND merge", gate_req, 4'b0001);
        pulse(1, 1);
        at_check();
        chk("R7 both strobes keep AND", gate_req, 4'b0001);
        pulse(1, 0);
        at_check();
        chk("R7 OR selected", gate_req, 4'b0111);
        chk("R4 OR merge", gate_req, 4'b0111);
        @(negedge clk); prot_off = 4'b0100;
        at_check();
        chk("R9 forced off", gate_req, 4'b0011);
        @(negedge clk); prot_off = '0;
        at_check();
        chk("R9 released", gate_req, 4'b0111);
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            pin_raw   = NCH'($urandom);
            data_bits = NCH'($urandom);
            if ($urandom_range(0, 15) == 0) pol_strap = ~pol_strap;
            set_or    = ($urandom_range(0, 7) == 0);
            set_and   = ($urandom_range(0, 7) == 0);
            prot_off  = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
            rst_n     = ($urandom_range(0, 49) != 0);
        end
        @(negedge clk); rst_n = 1; set_or = 0; set_and = 0;
        at_check(); at_check();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule